// File: doc/BRIEF.md
# Thermal-Limited Performance-State Selector

This block picks the frequency/voltage operating point of one thermal domain from an ordered list of seven discrete performance states: three boost states above the nominal top state, then four nominal states down to the slowest one. State index 0 is the fastest boost state, index 1 and 2 the slower boost states, index 3 the nominal top state and index 6 the slowest state. The block outputs the chosen index together with the frequency and voltage codes that belong to it.

Decisions happen only on a control tick, produced by an internal counter whose period is set by a programmable interval input. On each tick the block compares a calculated temperature against a limit and moves at most one step along the list. A step toward the faster end is taken only when the domain is cooler than the limit. A step toward the slower end is taken when it is hotter than the limit, or when either current-limit flag is raised. Software sets a cap: the fastest index the selector may use.

Top module: `pstate_selector`

## Requirements
- R1: While reset is asserted and right after it, the state index is 6 (slowest) and no tick is pending until the counter reaches the interval.
- R2: A tick is raised for one cycle every interval+1 cycles (interval 0 means every cycle); the state index changes only on the clock edge where tick is high.
- R3: On a tick with no current-limit flag and temperature strictly below the limit, the index decreases by exactly one (one step faster), unless it already equals the cap.
- R4: On a tick with no current-limit flag and temperature strictly above the limit, the index increases by exactly one (one step slower).
- R5: On a tick with temperature equal to the limit and no current-limit flag, the index is held.
- R6: The index saturates: it never goes below 0 nor above 6.
- R7: On a tick with either current-limit flag high (instantaneous or sustained), the index increases by one (saturating at 6) whatever the temperature; no faster step is taken on that tick.
- R8: The cap is the fastest index allowed; a cap above 6 acts as 6. If on a tick the index is faster than the cap, the index becomes the cap on that edge, before any other rule.
- R9: The frequency code equals 200 - 20 x index and the voltage code equals 150 - 10 x index (default parameters), following the index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval | input | 12 | Tick period minus one, in cycles |
| temp_calc | input | 10 | Calculated temperature |
| temp_limit | input | 10 | Temperature limit |
| edc_viol | input | 1 | Instantaneous current limit exceeded |
| tdc_viol | input | 1 | Sustained current limit exceeded |
| cap_idx | input | 3 | Fastest state index software allows |
| tick | output | 1 | Control decision taken this cycle |
| state_idx | output | 3 | Selected state index, 0 fastest |
| freq_code | output | 8 | Frequency code of the selected state |
| volt_code | output | 8 | Voltage code of the selected state |

## Verification
The bench drives the selector into both ends of the list and holds it there, so a design that wrapped the 3-bit index instead of saturating would jump from the fastest state to the slowest one or to the illegal code 7. It raises current-limit flags while the domain is cool, where a design that let temperature win would climb instead of throttling, and lowers the cap below the present state, where a design that only blocked further rises would stay too fast. Intervals are changed mid-count, including to zero and to a value below the current count, so a counter that tested equality would stall for thousands of cycles.

// File: rtl/pstate_selector.sv
module pstate_selector #(
  parameter int NUM_STATES = 7,
  parameter int IDX_W      = $clog2(NUM_STATES),
  parameter int TEMP_W     = 10,
  parameter int IVL_W      = 12,
  parameter int FREQ_W     = 8,
  parameter int FREQ_TOP   = 200,
  parameter int FREQ_STEP  = 20,
  parameter int VOLT_W     = 8,
  parameter int VOLT_TOP   = 150,
  parameter int VOLT_STEP  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  interval,
  input  logic [TEMP_W-1:0] temp_calc,
  input  logic [TEMP_W-1:0] temp_limit,
  input  logic              edc_viol,
  input  logic              tdc_viol,
  input  logic [IDX_W-1:0]  cap_idx,
  output logic              tick,
  output logic [IDX_W-1:0]  state_idx,
  output logic [FREQ_W-1:0] freq_code,
  output logic [VOLT_W-1:0] volt_code
);
  localparam logic [IDX_W-1:0]  MIN_IDX = IDX_W'(NUM_STATES - 1);
  localparam logic [FREQ_W-1:0] F_TOP   = FREQ_W'(FREQ_TOP);
  localparam logic [FREQ_W-1:0] F_STEP  = FREQ_W'(FREQ_STEP);
  localparam logic [VOLT_W-1:0] V_TOP   = VOLT_W'(VOLT_TOP);
  localparam logic [VOLT_W-1:0] V_STEP  = VOLT_W'(VOLT_STEP);

  logic [IVL_W-1:0] cnt;
  logic [IDX_W-1:0] cap_eff, nxt;
  logic             over_i, hot, cool;

  assign tick    = (cnt >= interval);
  assign cap_eff = (cap_idx > MIN_IDX) ? MIN_IDX : cap_idx;
  assign over_i  = edc_viol | tdc_viol;
  assign hot     = temp_calc > temp_limit;
  assign cool    = temp_calc < temp_limit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;

  always_comb begin
    nxt = state_idx;
    if (state_idx < cap_eff)
      nxt = cap_eff;
    else if (over_i || hot)
      nxt = (state_idx == MIN_IDX) ? MIN_IDX : state_idx + 1'b1;
    else if (cool && state_idx > cap_eff)
      nxt = state_idx - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    state_idx <= MIN_IDX;
    else if (tick) state_idx <= nxt;

  assign freq_code = F_TOP - F_STEP * FREQ_W'(state_idx);
  assign volt_code = V_TOP - V_STEP * VOLT_W'(state_idx);
endmodule

module pstate_selector_chk #(
  parameter int IDX_W      = 3,
  parameter int NUM_STATES = 7,
  parameter int FREQ_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              edc_viol,
  input logic              tdc_viol,
  input logic [IDX_W-1:0]  cap_idx,
  input logic [IDX_W-1:0]  state_idx,
  input logic [FREQ_W-1:0] freq_code
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STATES - 1);
  logic [IDX_W-1:0] capc;
  assign capc = (cap_idx > LAST) ? LAST : cap_idx;

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_idx));

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    state_idx <= LAST);

  a_r7_no_rise_on_viol: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (edc_viol || tdc_viol)) |=> state_idx >= $past(state_idx));

  a_r8_cap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> state_idx >= $past(capc));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state_idx >= capc) |=>
      (state_idx == $past(state_idx)) ||
      (state_idx == $past(state_idx) + 1'b1) ||
      (state_idx + 1'b1 == $past(state_idx)));

  a_r9_freq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_idx) |-> !$stable(freq_code));
endmodule

bind pstate_selector pstate_selector_chk #(
  .IDX_W(IDX_W), .NUM_STATES(NUM_STATES), .FREQ_W(FREQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .edc_viol(edc_viol),
  .tdc_viol(tdc_viol), .cap_idx(cap_idx), .state_idx(state_idx),
  .freq_code(freq_code)
);

// File: tb/tb_pstate_selector.sv
`timescale 1ns/1ps
module tb_pstate_selector;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [11:0] interval = 12'd3;
  logic [9:0] temp_calc = 10'd100, temp_limit = 10'd100;
  logic       edc_viol = 0, tdc_viol = 0;
  logic [2:0] cap_idx = 3'd0;
  logic       tick;
  logic [2:0] state_idx;
  logic [7:0] freq_code, volt_code;

  int total = 0, bad = 0;
  bit finished = 0;

  pstate_selector dut (
    .clk(clk), .rst_n(rst_n), .interval(interval), .temp_calc(temp_calc),
    .temp_limit(temp_limit), .edc_viol(edc_viol), .tdc_viol(tdc_viol),
    .cap_idx(cap_idx), .tick(tick), .state_idx(state_idx),
    .freq_code(freq_code), .volt_code(volt_code)
  );

  always #2.5 clk = ~clk;

  int    m_cnt = 0;
  int    m_st = 6;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 6; m_tag = "R1";
    end else if (m_cnt >= int'(interval)) begin
      int c;
      c = (int'(cap_idx) > 6) ? 6 : int'(cap_idx);
      m_cnt = 0;
      if (m_st < c) begin m_st = c; m_tag = "R8"; end
      else if (edc_viol || tdc_viol) begin
        if (m_st == 6) m_tag = "R6"; else begin m_st++; m_tag = "R7"; end
      end else if (temp_calc > temp_limit) begin
        if (m_st == 6) m_tag = "R6"; else begin m_st++; m_tag = "R4"; end
      end else if (temp_calc < temp_limit) begin
        if (m_st > c) begin m_st--; m_tag = "R3"; end
        else m_tag = (m_st == 0) ? "R6" : "R8";
      end else m_tag = "R5";
    end else begin
      m_cnt++; m_tag = "R2";
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk(state_idx == 3'(m_st), m_tag, state_idx, m_st);
    chk(tick == (m_cnt >= int'(interval)), "R2", tick, int'(m_cnt >= int'(interval)));
    chk(int'(freq_code) == 200 - 20 * m_st, "R9", freq_code, 200 - 20 * m_st);
    chk(int'(volt_code) == 150 - 10 * m_st, "R9", volt_code, 150 - 10 * m_st);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic set_temp(int t); temp_calc = 10'(t); endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(state_idx == 3'd6, "R1", state_idx, 6);
    rst_n = 1;
    step(1);
    chk(state_idx == 3'd6, "R1", state_idx, 6);
    set_temp(50);  step(40);
    chk(state_idx == 3'd0, "R3", state_idx, 0);
    step(8);
    chk(state_idx == 3'd0, "R6", state_idx, 0);
    set_temp(150); step(40);
    chk(state_idx == 3'd6, "R4", state_idx, 6);
    step(8);
    chk(state_idx == 3'd6, "R6", state_idx, 6);
    set_temp(50);  step(12);
    set_temp(100); step(30);
    chk(state_idx == 3'd3, "R5", state_idx, 3);
    set_temp(50);  step(20);
    edc_viol = 1;  step(12);
    chk(state_idx == 3'd3, "R7", state_idx, 3);
    edc_viol = 0; tdc_viol = 1; step(12);
    chk(state_idx == 3'd6, "R7", state_idx, 6);
    tdc_viol = 0;  step(40);
    cap_idx = 3'd2; step(8);
    chk(state_idx == 3'd2, "R8", state_idx, 2);
    cap_idx = 3'd7; step(8);
    chk(state_idx == 3'd6, "R8", state_idx, 6);
    cap_idx = 3'd0;
    interval = 12'd0; step(10);
    chk(state_idx == 3'd0, "R2", state_idx, 0);
    interval = 12'd9; set_temp(150); step(25);
    interval = 12'd2; step(20);
    for (int i = 0; i < 3000; i++) begin
      set_temp(95 + int'($urandom_range(0, 10)));
      edc_viol = ($urandom_range(0, 9) == 0);
      tdc_viol = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) cap_idx = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) == 0) interval = 12'($urandom_range(0, 5));
      step(1);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule